// File: doc/BRIEF.md
# Transmit FIFO Start Gate

This block sits beside the packet FIFO of an asynchronous transmit engine and decides when the engine may start draining the head packet onto the serial link. It counts the words of the packet being loaded into the FIFO. It grants a start as soon as that count reaches a programmable threshold, or as soon as the whole packet up to its end-of-packet word is loaded, whichever comes first. The FIFO is 32 bits wide and 2048 bytes deep. Thresholds are therefore compared in 32-bit words.

Starting before the whole packet is loaded cuts latency, but the upstream bus master may then fall behind the drain. If the FIFO runs dry before the end-of-packet word of a started packet arrives, the packet is lost on the wire. The block then enters retry mode: the rewritten packet is only released once it is completely loaded (store-and-forward). The programmed threshold applies again after that retry finishes cleanly.

Complete packets that queue up behind a packet in flight are counted. Each is released in order once the drain side reports the previous one done.

Top module: `tx_start_gate`

## Requirements
- R1: While reset is asserted, and right after it is released, `startOk` and `retryMode` are 0.
- R2: With `enhanceEn`=1, `thrSel` picks the early-start level in words: 01 gives 432 (reset default, about 1.7 KB), 10 gives 256 (1 KB) and 11 gives 128 (512 bytes). `startOk` rises one clock after the edge that loads that word of the packet.
- R3: With `enhanceEn`=1 and `thrSel`=00, the start waits for the end-of-packet word (store-and-forward, about 2 KB). `startOk` rises one clock after the edge that loads that word, even for packets longer than any other threshold.
- R4: A packet shorter than the selected threshold starts one clock after its end-of-packet word is loaded.
- R5: With `enhanceEn`=0, every `thrSel` value behaves as 01 (432 words).
- R6: Once raised, `startOk` stays 1 until `txDone` or an underrun is seen at a clock edge. It is 0 after that edge.
- R7: An underrun is `txUnderrun`=1, or `fifoLevel`=0 while a packet started early still lacks its end-of-packet word, at an edge where `startOk`=1. After that edge `startOk` is 0 and `retryMode` is 1.
- R8: The remaining words of the errored packet never cause a start. In retry mode the rewritten packet starts only one clock after its end-of-packet word is loaded, whatever the threshold.
- R9: `retryMode` clears at the edge where `txDone` ends the retried packet. The next packet uses the programmed threshold again.
- R10: The word count restarts at every end-of-packet word. Complete packets loaded behind a packet in flight are held, then each starts in order, one clock after the `txDone` edge of its predecessor.
- R11: `txDone` and `txUnderrun` while `startOk`=0 have no effect on `startOk` or `retryMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| thrSel | input | 2 | Early-start threshold select (00 store-and-forward, 01 432, 10 256, 11 128 words) |
| enhanceEn | input | 1 | Global enable for non-default threshold settings |
| wrValid | input | 1 | One FIFO word written this cycle |
| wrEop | input | 1 | The written word is the packet's last (valid with `wrValid`) |
| fifoLevel | input | CNT_W (10) | Current FIFO occupancy in words |
| txDone | input | 1 | Drain side finished the started packet |
| txUnderrun | input | 1 | Drain side reports underrun on the started packet |
| startOk | output | 1 | Transmit engine may drain the head packet |
| retryMode | output | 1 | Store-and-forward forced after an underrun |

## Verification
The hardest state to reach is an underrun on a packet that was released early, followed by the loading of the rest of that errored packet. Those tail words must be absorbed without a second start. After that, the rewrite must be held back until its last word. The stimulus gets there by choosing a packet longer than the threshold and pausing the writer right after the threshold start. It then forces the underrun, once through the drain-side pulse and once by dropping the FIFO level to zero. Only then does it load the tail and the full rewrite. A scoreboard compares, at each rising `startOk`, the number of words the bench has loaded for the head packet against the count the requirements predict.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef enum logic [1:0] {
    SEL_STORE   = 2'b00,
    SEL_DEFAULT = 2'b01,
    SEL_HALF    = 2'b10,
    SEL_QUARTER = 2'b11
  } thrSel_e;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_SEND = 1'b1
  } gateState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic grantHead;     // release oldest complete queued packet
    logic grantLoading;  // release packet still being loaded (threshold start)
  } ctlStrobe_t;

endpackage

// File: rtl/txs_thresh.sv
module txs_thresh
  import txs_pkg::*;
#(
  parameter int DEPTH_WORDS   = 512,
  parameter int DEFAULT_WORDS = 432,
  parameter int CNT_W         = 10
) (
  input  logic [1:0]       thrSel,
  input  logic             enhanceEn,
  output logic [CNT_W-1:0] thrWords,
  output logic             sfSelected
);

  localparam logic [CNT_W-1:0] THR_FULL    = CNT_W'(DEPTH_WORDS);
  localparam logic [CNT_W-1:0] THR_DEFAULT = CNT_W'(DEFAULT_WORDS);
  localparam logic [CNT_W-1:0] THR_HALF    = CNT_W'(DEPTH_WORDS / 2);
  localparam logic [CNT_W-1:0] THR_QUARTER = CNT_W'(DEPTH_WORDS / 4);

  thrSel_e effSel;

  // a disabled enhancement falls back to the default setting
  assign effSel = enhanceEn ? thrSel_e'(thrSel) : SEL_DEFAULT;

  always_comb begin
    sfSelected = 1'b0;
    thrWords   = THR_DEFAULT;
    case (effSel)
      SEL_STORE: begin
        thrWords   = THR_FULL;
        sfSelected = 1'b1;
      end
      SEL_DEFAULT: thrWords = THR_DEFAULT;
      SEL_HALF:    thrWords = THR_HALF;
      SEL_QUARTER: thrWords = THR_QUARTER;
      default:     thrWords = THR_DEFAULT;
    endcase
  end

endmodule

// File: rtl/txs_datapath.sv
module txs_datapath
  import txs_pkg::*;
#(
  parameter int DEPTH_WORDS = 512,
  parameter int CNT_W       = 10,
  parameter int PKT_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             wrEop,
  input  ctlStrobe_t       strb,
  output logic [CNT_W-1:0] wordCount,
  output logic             headFull,
  output logic             loadingGranted
);

  localparam logic [CNT_W-1:0] COUNT_CAP = CNT_W'(DEPTH_WORDS);
  localparam logic [PKT_W-1:0] PKT_MAX   = '1;

  logic [PKT_W-1:0] fullPkts;
  logic             eopWr;
  logic             pktIn;

  assign eopWr = wrValid & wrEop;
  // a packet already released early does not join the complete-packet queue
  assign pktIn = eopWr & ~(loadingGranted | strb.grantLoading);
  assign headFull = (fullPkts != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCount      <= '0;
      fullPkts       <= '0;
      loadingGranted <= 1'b0;
    end else begin
      if (wrValid) begin
        if (wrEop)                       wordCount <= '0;
        else if (wordCount != COUNT_CAP) wordCount <= wordCount + CNT_W'(1);
      end
      case ({pktIn, strb.grantHead})
        2'b10:   fullPkts <= fullPkts + PKT_W'(1);
        2'b01:   fullPkts <= fullPkts - PKT_W'(1);
        default: fullPkts <= fullPkts;
      endcase
      loadingGranted <= (loadingGranted | strb.grantLoading) & ~eopWr;
    end
  end

  // R10: the queue of complete packets never wraps
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fullPkts == PKT_MAX) |-> !(pktIn && !strb.grantHead));

  // R8: a single release source per cycle
  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.grantHead, strb.grantLoading}));

endmodule

// File: rtl/txs_control.sv
module txs_control
  import txs_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] thrWords,
  input  logic             sfSelected,
  input  logic [CNT_W-1:0] wordCount,
  input  logic             headFull,
  input  logic             loadingGranted,
  input  logic [CNT_W-1:0] fifoLevel,
  input  logic             txDone,
  input  logic             txUnderrun,
  output ctlStrobe_t       strb,
  output logic             startOk,
  output logic             retryMode
);

  gateState_e state, nextState;
  logic       retryNext;
  logic       sfMode;
  logic       underrunEvt;

  assign sfMode      = sfSelected | retryMode;
  assign underrunEvt = (state == ST_SEND) &&
                       (txUnderrun || (loadingGranted && (fifoLevel == '0)));

  always_comb begin
    strb      = '0;
    nextState = state;
    retryNext = retryMode;
    case (state)
      ST_WAIT: begin
        if (headFull) begin
          strb.grantHead = 1'b1;
          nextState      = ST_SEND;
        end else if (!sfMode && !loadingGranted && (wordCount >= thrWords)) begin
          strb.grantLoading = 1'b1;
          nextState         = ST_SEND;
        end
      end
      ST_SEND: begin
        if (underrunEvt) begin
          nextState = ST_WAIT;
          retryNext = 1'b1;
        end else if (txDone) begin
          nextState = ST_WAIT;
          retryNext = 1'b0;
        end
      end
      default: nextState = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_WAIT;
      retryMode <= 1'b0;
    end else begin
      state     <= nextState;
      retryMode <= retryNext;
    end
  end

  assign startOk = (state == ST_SEND);

  // R6: permission holds while nothing ends the packet
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (startOk && !txDone && !txUnderrun && !(loadingGranted && fifoLevel == '0))
      |=> startOk);

  // R7: a reported underrun withdraws permission and forces retry
  assert_underrun_retry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (startOk && txUnderrun) |=> (retryMode && !startOk));

  // R8: in retry mode only a complete packet is released
  assert_sf_complete_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(startOk) && retryMode) |-> $past(headFull));

  // R2: any release is backed by a complete packet or a reached threshold
  assert_thresh_reached_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startOk) |-> $past(headFull || (wordCount >= thrWords)));

  // R9: retry ends only through a clean completion
  assert_retry_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(retryMode) |-> $past(startOk && txDone));

  // R11: drain-side pulses while idle leave retry untouched
  assert_idle_ignore_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!startOk && !retryMode) |=> !retryMode);

endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate
  import txs_pkg::*;
#(
  parameter int FIFO_BYTES    = 2048,
  parameter int WORD_BYTES    = 4,
  parameter int DEFAULT_WORDS = 432,
  parameter int PKT_W         = 4,
  parameter int CNT_W         = $clog2(FIFO_BYTES / WORD_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       thrSel,
  input  logic             enhanceEn,
  input  logic             wrValid,
  input  logic             wrEop,
  input  logic [CNT_W-1:0] fifoLevel,
  input  logic             txDone,
  input  logic             txUnderrun,
  output logic             startOk,
  output logic             retryMode
);

  localparam int DEPTH_WORDS = FIFO_BYTES / WORD_BYTES;

  logic [CNT_W-1:0] thrWords;
  logic             sfSelected;
  logic [CNT_W-1:0] wordCount;
  logic             headFull;
  logic             loadingGranted;
  ctlStrobe_t       strb;

  txs_thresh #(
    .DEPTH_WORDS  (DEPTH_WORDS),
    .DEFAULT_WORDS(DEFAULT_WORDS),
    .CNT_W        (CNT_W)
  ) u_thresh (
    .thrSel    (thrSel),
    .enhanceEn (enhanceEn),
    .thrWords  (thrWords),
    .sfSelected(sfSelected)
  );

  txs_datapath #(
    .DEPTH_WORDS(DEPTH_WORDS),
    .CNT_W      (CNT_W),
    .PKT_W      (PKT_W)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .wrValid       (wrValid),
    .wrEop         (wrEop),
    .strb          (strb),
    .wordCount     (wordCount),
    .headFull      (headFull),
    .loadingGranted(loadingGranted)
  );

  txs_control #(
    .CNT_W(CNT_W)
  ) u_control (
    .clk           (clk),
    .rstN          (rstN),
    .thrWords      (thrWords),
    .sfSelected    (sfSelected),
    .wordCount     (wordCount),
    .headFull      (headFull),
    .loadingGranted(loadingGranted),
    .fifoLevel     (fifoLevel),
    .txDone        (txDone),
    .txUnderrun    (txUnderrun),
    .strb          (strb),
    .startOk       (startOk),
    .retryMode     (retryMode)
  );

endmodule

// File: tb/tx_start_gate_bench.sv
module tx_start_gate_bench;

  localparam int CNT_W = 10;

  logic             clk = 1'b0;
  logic             rstN;
  logic [1:0]       thrSel;
  logic             enhanceEn;
  logic             wrValid;
  logic             wrEop;
  logic [CNT_W-1:0] fifoLevel;
  logic             txDone;
  logic             txUnderrun;
  logic             startOk;
  logic             retryMode;

  always #4 clk = ~clk;  // 125 MHz

  tx_start_gate u_tx_start_gate (
    .clk       (clk),
    .rstN      (rstN),
    .thrSel    (thrSel),
    .enhanceEn (enhanceEn),
    .wrValid   (wrValid),
    .wrEop     (wrEop),
    .fifoLevel (fifoLevel),
    .txDone    (txDone),
    .txUnderrun(txUnderrun),
    .startOk   (startOk),
    .retryMode (retryMode)
  );

  typedef struct {
    int    words;
    bit    retry;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int  loaded[64];
  int  curPkt   = 0;
  int  grantIdx = 0;
  int  checks   = 0;
  int  fails    = 0;
  bit  prevStart = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: compare each new start against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN === 1'b1) begin
        if (startOk && !prevStart) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R10", "unexpected start", 1, 0);
          end else begin
            expItem_t e;
            e = expQ.pop_front();
            check(loaded[grantIdx] == e.words, e.req, "words loaded at start",
                  loaded[grantIdx], e.words);
            check(retryMode == e.retry, e.req, "retryMode at start",
                  int'(retryMode), int'(e.retry));
            grantIdx++;
          end
        end
        prevStart = startOk;
      end
    end
  end

  task automatic expectStart(input int words, input bit retry, input string req);
    expItem_t e;
    e.words = words;
    e.retry = retry;
    e.req   = req;
    expQ.push_back(e);
  endtask

  task automatic writeWords(input int n, input bit eopLast);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrValid = 1'b1;
      wrEop   = eopLast && (i == n - 1);
      loaded[curPkt]++;
      if (wrEop) curPkt++;
      @(negedge clk);
      wrValid = 1'b0;
      wrEop   = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseDone(input string req);
    @(negedge clk);
    txDone = 1'b1;
    @(posedge clk);
    #1;
    check(startOk == 1'b0, req, "startOk after done", int'(startOk), 0);
    @(negedge clk);
    txDone = 1'b0;
  endtask

  task automatic checkStarted(input string req);
    check(startOk == 1'b1, req, "startOk held", int'(startOk), 1);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) loaded[i] = 0;
    rstN       = 1'b0;
    thrSel     = 2'b01;
    enhanceEn  = 1'b1;
    wrValid    = 1'b0;
    wrEop      = 1'b0;
    fifoLevel  = '0;
    txDone     = 1'b0;
    txUnderrun = 1'b0;
    idle(3);
    check(startOk == 1'b0, "R1", "startOk in reset", int'(startOk), 0);
    check(retryMode == 1'b0, "R1", "retryMode in reset", int'(retryMode), 0);
    rstN = 1'b1;
    fifoLevel = 10'd100;
    idle(2);
    check(startOk == 1'b0, "R1", "startOk after reset", int'(startOk), 0);

    // R2: default setting, 432 words
    expectStart(432, 1'b0, "R2");
    writeWords(500, 1'b1);
    idle(2);
    checkStarted("R6");
    pulseDone("R6");

    // R2: 256 words
    thrSel = 2'b10;
    expectStart(256, 1'b0, "R2");
    writeWords(300, 1'b1);
    idle(2);
    pulseDone("R2");

    // R2: 128 words
    thrSel = 2'b11;
    expectStart(128, 1'b0, "R2");
    writeWords(200, 1'b1);
    idle(2);
    pulseDone("R2");

    // R3: store-and-forward waits for the last word
    thrSel = 2'b00;
    expectStart(300, 1'b0, "R3");
    writeWords(300, 1'b1);
    idle(2);
    pulseDone("R3");

    // R4: short packet
    thrSel = 2'b11;
    expectStart(100, 1'b0, "R4");
    writeWords(100, 1'b1);
    idle(2);
    pulseDone("R4");

    // R5: enhancement disabled falls back to 432 words
    enhanceEn = 1'b0;
    thrSel = 2'b11;
    expectStart(432, 1'b0, "R5");
    writeWords(500, 1'b1);
    idle(2);
    pulseDone("R5");
    thrSel = 2'b00;
    expectStart(432, 1'b0, "R5");
    writeWords(450, 1'b1);
    idle(2);
    pulseDone("R5");
    enhanceEn = 1'b1;

    // R11: drain-side pulses while idle
    @(negedge clk);
    txDone = 1'b1;
    txUnderrun = 1'b1;
    @(posedge clk);
    #1;
    check(startOk == 1'b0, "R11", "startOk after idle pulses", int'(startOk), 0);
    check(retryMode == 1'b0, "R11", "retryMode after idle pulses", int'(retryMode), 0);
    @(negedge clk);
    txDone = 1'b0;
    txUnderrun = 1'b0;
    idle(2);
    check(retryMode == 1'b0, "R11", "retryMode later", int'(retryMode), 0);

    // R7/R8/R9: underrun reported by the drain side
    thrSel = 2'b11;
    expectStart(128, 1'b0, "R7");
    writeWords(150, 1'b0);
    @(negedge clk);
    txUnderrun = 1'b1;
    @(posedge clk);
    #1;
    check(startOk == 1'b0, "R7", "startOk after underrun", int'(startOk), 0);
    check(retryMode == 1'b1, "R7", "retryMode after underrun", int'(retryMode), 1);
    @(negedge clk);
    txUnderrun = 1'b0;
    writeWords(150, 1'b1);
    idle(3);
    check(startOk == 1'b0, "R8", "no start on errored tail", int'(startOk), 0);
    expectStart(300, 1'b1, "R8");
    writeWords(300, 1'b1);
    idle(2);
    checkStarted("R8");
    pulseDone("R9");
    check(retryMode == 1'b0, "R9", "retryMode after clean retry", int'(retryMode), 0);
    expectStart(128, 1'b0, "R9");
    writeWords(200, 1'b1);
    idle(2);
    pulseDone("R9");

    // R7/R8: underrun seen as an empty FIFO before the last word
    thrSel = 2'b10;
    expectStart(256, 1'b0, "R7");
    writeWords(300, 1'b0);
    @(negedge clk);
    fifoLevel = '0;
    @(posedge clk);
    #1;
    check(startOk == 1'b0, "R7", "startOk after empty FIFO", int'(startOk), 0);
    check(retryMode == 1'b1, "R7", "retryMode after empty FIFO", int'(retryMode), 1);
    @(negedge clk);
    fifoLevel = 10'd100;
    writeWords(100, 1'b1);
    expectStart(400, 1'b1, "R8");
    writeWords(400, 1'b1);
    idle(2);
    pulseDone("R9");

    // R10: count restarts after each last word
    thrSel = 2'b11;
    expectStart(100, 1'b0, "R10");
    writeWords(100, 1'b1);
    idle(2);
    pulseDone("R10");
    expectStart(128, 1'b0, "R10");
    writeWords(200, 1'b1);
    idle(2);
    pulseDone("R10");

    // R10: back-to-back complete packets
    expectStart(60, 1'b0, "R10");
    expectStart(70, 1'b0, "R10");
    writeWords(60, 1'b1);
    writeWords(70, 1'b1);
    idle(2);
    checkStarted("R10");
    pulseDone("R10");
    idle(3);
    checkStarted("R10");
    pulseDone("R10");
    idle(3);

    check(expQ.size() == 0, "R10", "pending expected starts", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule